// File: doc/BRIEF.md
# Read-to-Clear Interrupt Controller

This block gathers single-cycle event pulses from up to eight sources (energy half-full, energy wrap, new waveform sample, line sag, temperature conversion done and others) into an 8-bit sticky status register. An 8-bit enable register picks which flags may pull the active-low interrupt line. Every event is latched whatever its enable bit says, so software can poll the status of masked sources.

Software reads the status through a serial port. The port logic upstream gives this block three one-cycle markers: the end of the command byte (with a flag that says whether the read also clears), and the end of the data byte. At the command-byte boundary the block takes a snapshot of the status for the data byte. A clearing read removes exactly the snapshotted bits and forces the interrupt line inactive until the data byte has gone out. Events that land during the transfer stay latched and pull the line low again once the byte is complete.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is low on a clock edge, the status flags, enable register and snapshot all become zero and `irq_n_o` is 1 after that edge.
- R2: An event pulse on bit i sets status flag i on the next edge, whether or not enable bit i is 1.
- R3: Outside a clearing read, `irq_n_o` is 0 exactly when some status flag and its matching enable bit are both 1. The line changes after the edge that updates the flag or the enable.
- R4: A command marker with the clear flag at 0 loads the current status into `rd_data_o` on that edge and leaves every status flag unchanged.
- R5: A command marker with the clear flag at 1 loads the current status into `rd_data_o` and clears those captured flags on the same edge.
- R6: From the edge that registers a clearing command marker until the edge that registers the data-done marker, `irq_n_o` stays 1.
- R7: An event that arrives during a clearing read stays latched. If it is enabled, `irq_n_o` goes to 0 right after the data-done edge.
- R8: When an event and a clearing capture hit the same flag in the same cycle, the flag ends up set.
- R9: Bit 5 carries the temperature-conversion-done event and is gated only by enable bit 5.
- R10: An enable write takes effect on the edge it is sampled, and `irq_n_o` follows the new mask from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 8 | One-cycle event pulses, one bit per source |
| en_wr_i | input | 1 | Enable register write strobe |
| en_data_i | input | 8 | New enable mask |
| cmd_done_i | input | 1 | Command byte of a status read has completed |
| cmd_clear_i | input | 1 | With `cmd_done_i`: 1 selects the clearing read |
| data_done_i | input | 1 | Last bit of the status data byte has been shifted out |
| rd_data_o | output | 8 | Status snapshot for the data byte |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The checker watches, on every cycle, the local rules: events latch on the next edge, a plain read keeps every flag, a clearing read leaves only the same-cycle events, the snapshot equals the status of the capture edge, and the line stays high for the whole clearing window. The full orderings can only be shown by the bench scenarios. These include an event that arrives mid-transfer and reasserts the line after the byte, an event that coincides with the clear, a masked temperature flag that polling still reveals, and the line following a rewritten mask.

// File: rtl/irqc_pkg.sv
// Package: shared constants and the serial-transfer marker type for the
// read-to-clear interrupt controller.
package irqc_pkg;

    // Number of event sources handled by default.
    localparam int unsigned IRQC_SRC_DEF = 8;

    // Markers that the serial port logic delivers, one cycle each.
    typedef struct packed {
        logic cmd_done;   // command byte finished
        logic cmd_clear;  // command selects the clearing read
        logic data_done;  // data byte finished
    } xfer_mark_t;

endpackage

// File: rtl/irqc_flag_bank.sv
// Module: sticky status flags.
// Each flag is set by its event pulse and cleared by a capture-clear
// strobe. Only the bits captured at that edge are cleared, and a
// same-cycle event wins over the clear.
// Assumes: event pulses are synchronous to clk and one cycle wide.
module irqc_flag_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_take,
    output logic [N-1:0] status_q
);

    logic [N-1:0] clr_mask;

    // Purpose: pick the bits to clear, which are the ones being captured now.
    always_comb begin
        clr_mask = clr_take ? status_q : '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: per-bit set/clear with the event taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (evt[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqc_capture.sv
// Module: status snapshot for the serial data byte.
// Loads the status at the command-byte boundary and holds it until the
// next read.
// Assumes: take is a one-cycle marker.
module irqc_capture #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [N-1:0] status,
    output logic [N-1:0] snap_q
);

    // Purpose: hold the last captured status value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (take) begin
            snap_q <= status;
        end
    end

endmodule

// File: rtl/irqc_gate.sv
// Module: enable mask, clearing-read window and interrupt output.
// The line is low when an enabled flag is pending and no clearing read is
// in its data phase.
// Assumes: a clearing read always ends with a data_done marker. A new
// command marker takes priority over a data_done in the same cycle.
module irqc_gate
    import irqc_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic [N-1:0] en_data,
    input  xfer_mark_t   mark,
    input  logic [N-1:0] status,
    output logic [N-1:0] enable_q,
    output logic         hold_q,
    output logic         irq_n
);

    logic pending;

    // Purpose: enable register, written as a whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_wr) begin
            enable_q <= en_data;
        end
    end

    // Purpose: mask window from the clearing command to the end of the data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (mark.cmd_done && mark.cmd_clear) begin
            hold_q <= 1'b1;
        end else if (mark.data_done) begin
            hold_q <= 1'b0;
        end
    end

    // Purpose: combine pending enabled flags with the mask window.
    always_comb begin
        pending = |(status & enable_q);
        irq_n   = !(pending && !hold_q);
    end

endmodule

// File: rtl/irq_status_ctrl.sv
// Module: top of the read-to-clear interrupt controller.
// Connects the flag bank, the snapshot register and the interrupt gate.
// Assumes: the serial port logic supplies the one-cycle markers in the
// order command-done, then data-done.
module irq_status_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = IRQC_SRC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             en_wr_i,
    input  logic [N_SRC-1:0] en_data_i,
    input  logic             cmd_done_i,
    input  logic             cmd_clear_i,
    input  logic             data_done_i,
    output logic [N_SRC-1:0] rd_data_o,
    output logic             irq_n_o
);

    xfer_mark_t       mark;
    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] enable_q;
    logic             hold_q;
    logic             clr_take;

    // Purpose: bundle the transfer markers and derive the clear strobe.
    always_comb begin
        mark.cmd_done  = cmd_done_i;
        mark.cmd_clear = cmd_clear_i;
        mark.data_done = data_done_i;
        clr_take       = cmd_done_i && cmd_clear_i;
    end

    irqc_flag_bank #(.N(N_SRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr_take (clr_take),
        .status_q (status_q)
    );

    irqc_capture #(.N(N_SRC)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (cmd_done_i),
        .status (status_q),
        .snap_q (rd_data_o)
    );

    irqc_gate #(.N(N_SRC)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr_i),
        .en_data  (en_data_i),
        .mark     (mark),
        .status   (status_q),
        .enable_q (enable_q),
        .hold_q   (hold_q),
        .irq_n    (irq_n_o)
    );

endmodule

// File: rtl/irq_status_ctrl_chk.sv
// Module: assertion checker for irq_status_ctrl, attached with bind.
// Assumes: internal status, enable and window signals are reachable by name.
module irq_status_ctrl_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] evt_i,
    input logic         cmd_done_i,
    input logic         cmd_clear_i,
    input logic [N-1:0] rd_data_o,
    input logic         irq_n_o,
    input logic [N-1:0] status_q,
    input logic [N-1:0] enable_q,
    input logic         hold_q
);

    // R1: a reset edge leaves flags, mask and snapshot empty and the line high.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && enable_q == '0 && rd_data_o == '0 && irq_n_o));

    // R2: every pulsed event is latched on the next edge, whatever the mask.
    a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

    // R4: a plain read loses no flag.
    a_r4_plain_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_i && !cmd_clear_i) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R5: the snapshot equals the status of the capture edge.
    a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_i |=> (rd_data_o == $past(status_q)));

    // R5: a clearing read leaves only the events of that same cycle (R8).
    a_r5_clear_leaves_events: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_i && cmd_clear_i) |=> (status_q == $past(evt_i)));

    // R6: the line is high right after a clearing command.
    a_r6_cmd_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_i && cmd_clear_i) |=> irq_n_o);

    // R6: the line stays high for as long as the window is open.
    a_r6_window_high: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> irq_n_o);

    // R7: when the window closes with an enabled flag pending, the line drops.
    a_r7_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_q) && (|(status_q & enable_q))) |-> !irq_n_o);

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.N(N_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .cmd_done_i  (cmd_done_i),
    .cmd_clear_i (cmd_clear_i),
    .rd_data_o   (rd_data_o),
    .irq_n_o     (irq_n_o),
    .status_q    (status_q),
    .enable_q    (enable_q),
    .hold_q      (hold_q)
);

// File: tb/tb_irq_status_ctrl.sv
// Scoreboard bench: the driver pushes expected {snapshot, line} items after
// each edge, and the monitor pops and compares them at the following
// falling edge.
module tb_irq_status_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       en_wr_i = 1'b0;
    logic [7:0] en_data_i = '0;
    logic       cmd_done_i = 1'b0;
    logic       cmd_clear_i = 1'b0;
    logic       data_done_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_n_o;

    typedef struct {
        string      req;
        logic [7:0] data;
        logic       irq_n;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .en_wr_i     (en_wr_i),
        .en_data_i   (en_data_i),
        .cmd_done_i  (cmd_done_i),
        .cmd_clear_i (cmd_clear_i),
        .data_done_i (data_done_i),
        .rd_data_o   (rd_data_o),
        .irq_n_o     (irq_n_o)
    );

    // Monitor: compare queued expectations away from the rising edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (rd_data_o !== e.data || irq_n_o !== e.irq_n) begin
                n_fail++;
                $display("FAIL %s: data=%02h irq_n=%0b expected data=%02h irq_n=%0b",
                         e.req, rd_data_o, irq_n_o, e.data, e.irq_n);
            end
        end
    end

    // Driver: apply one cycle of stimulus, sampled at the next rising edge.
    task automatic tick(input logic [7:0] ev, input logic wr, input logic [7:0] wd,
                        input logic cd, input logic cc, input logic dd);
        @(negedge clk);
        evt_i = ev; en_wr_i = wr; en_data_i = wd;
        cmd_done_i = cd; cmd_clear_i = cc; data_done_i = dd;
        @(posedge clk);
    endtask

    task automatic expect_item(input string req, input logic [7:0] d, input logic irq);
        exp_t e;
        e.req = req; e.data = d; e.irq_n = irq;
        exp_q.push_back(e);
    endtask

    task automatic idle();        tick(8'h00, 0, 8'h00, 0, 0, 0); endtask
    task automatic event_in(input logic [7:0] ev); tick(ev, 0, 8'h00, 0, 0, 0); endtask
    task automatic set_en(input logic [7:0] m);   tick(8'h00, 1, m, 0, 0, 0); endtask
    task automatic plain_rd();    tick(8'h00, 0, 8'h00, 1, 0, 0); endtask
    task automatic clear_rd(input logic [7:0] ev); tick(ev, 0, 8'h00, 1, 1, 0); endtask
    task automatic byte_end();    tick(8'h00, 0, 8'h00, 0, 0, 1); endtask

    task automatic finish_run();
        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: data=%02h irq_n=%0b expected scenario end", rd_data_o, irq_n_o);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle();                 expect_item("R1 reset state", 8'h00, 1'b1);

        // R2: masked event still latched and visible through a plain read.
        event_in(8'h01);        expect_item("R2 masked event keeps line high", 8'h00, 1'b1);
        plain_rd();             expect_item("R2 R4 plain read shows flag", 8'h01, 1'b1);
        plain_rd();             expect_item("R4 second plain read unchanged", 8'h01, 1'b1);

        // R10: enabling a pending flag drops the line.
        set_en(8'h01);          expect_item("R10 enable pending flag", 8'h01, 1'b0);

        // R5 R6: clearing read masks the line across the byte.
        clear_rd(8'h00);        expect_item("R5 R6 clearing capture", 8'h01, 1'b1);
        idle();                 expect_item("R6 window holds line high", 8'h01, 1'b1);
        byte_end();             expect_item("R5 cleared flag, line stays high", 8'h01, 1'b1);
        plain_rd();             expect_item("R5 flag cleared by read", 8'h00, 1'b1);

        // R3 R7: event during the window survives and reasserts.
        set_en(8'h03);          expect_item("R10 new mask, nothing pending", 8'h00, 1'b1);
        event_in(8'h02);        expect_item("R3 enabled event drops line", 8'h00, 1'b0);
        clear_rd(8'h00);        expect_item("R5 capture of bit 1", 8'h02, 1'b1);
        event_in(8'h01);        expect_item("R6 event inside window, line high", 8'h02, 1'b1);
        byte_end();             expect_item("R7 line reasserts after byte", 8'h02, 1'b0);
        plain_rd();             expect_item("R7 late event retained", 8'h01, 1'b0);

        // R8: event on the bit being cleared in the same cycle.
        clear_rd(8'h01);        expect_item("R8 capture with coincident event", 8'h01, 1'b1);
        byte_end();             expect_item("R8 bit survives, line low", 8'h01, 1'b0);
        plain_rd();             expect_item("R8 flag still set", 8'h01, 1'b0);
        clear_rd(8'h00);        expect_item("R5 clearing capture", 8'h01, 1'b1);
        byte_end();             expect_item("R5 all cleared, line high", 8'h01, 1'b1);

        // R9: temperature event on bit 5 gated only by enable bit 5.
        set_en(8'hDF);          expect_item("R9 all enables but bit 5", 8'h01, 1'b1);
        event_in(8'h20);        expect_item("R9 bit 5 masked", 8'h01, 1'b1);
        plain_rd();             expect_item("R9 R2 bit 5 latched", 8'h20, 1'b1);
        set_en(8'h20);          expect_item("R9 enable bit 5 drops line", 8'h20, 1'b0);
        set_en(8'h00);          expect_item("R10 mask removed, line high", 8'h20, 1'b1);

        // R3: several simultaneous events, only one enabled.
        set_en(8'h80);          expect_item("R10 mask bit 7", 8'h20, 1'b1);
        event_in(8'hC0);        expect_item("R3 multi event, bit 7 enabled", 8'h20, 1'b0);
        plain_rd();             expect_item("R2 R3 all three flags held", 8'hE0, 1'b0);

        // R1: reset in the middle of activity.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle();                 expect_item("R1 reset clears everything", 8'h00, 1'b1);
        event_in(8'h80);        expect_item("R1 enable cleared by reset", 8'h00, 1'b1);

        done = 1;
        finish_run();
    end

endmodule